// File: doc/BRIEF.md
# Memory Traffic Performance Monitor

This block counts memory controller activity so that software can measure bandwidth and utilisation across the whole system. Four event counters track read operations, write operations, bank-activate cycles and idle cycles. Each one is switched on by its own configuration bit. A fifth counter measures elapsed time in monitor clock cycles whenever the monitor runs, so every event count can be turned into a rate.

Software uses a simple register bus with an address, a write strobe, write data and combinational read data. With that bus it starts and stops the monitor, chooses which events count, clears counters and reads results. The event inputs are sampled once per cycle and may be one-cycle pulses or held levels. When a counter wraps, its sticky status bit is set, the interrupt goes high and the monitor stops, so all five counters hold values that belong together.

Top module: `mem_perf_monitor`

## Requirements
- R1: After reset the monitor is stopped, every counter, configuration bit and status bit reads zero, and irq_o is low.
- R2: Register addresses: run control 0x000 (bit 0 reads back the running state), event enables 0x004, overflow status 0x008, counter clear 0x00C (reads zero), elapsed time 0x020, event counter n at 0x030 + 8*n, version 0x3F4, ID 0x3F8. Any other address reads zero.
- R3: A write of 1 to bit 0 at 0x000 starts the monitor, and a write of 1 to bit 1 stops it. When both bits are set, stop wins. While the monitor is stopped, no counter changes.
- R4: While the monitor runs, the elapsed time counter rises by one every clock, whatever the enable bits say.
- R5: Event counter n (0 read, 1 write, 2 activate, 3 idle) rises by one in each cycle where the monitor runs, enable bit n at 0x004 is 1 and evt_i[n] is high.
- R6: A write to 0x00C zeroes event counter n for each set bit n in 0..3, and zeroes the time counter for bit 31, all in the cycle of the write. A clear wins over an increment in the same cycle. The value 0x8000000F clears all five counters together.
- R7: A counter at its maximum that increments wraps to zero and sets its status bit (bit n for event counter n, bit 31 for time). The monitor then stops, so all counters freeze from the next cycle on.
- R8: Status bits are sticky. A bit is cleared only by clearing its counter through 0x00C. irq_o is high exactly when any status bit is set.
- R9: A start command has no effect while any status bit is set.
- R10: Writes to status, counter, ID and version addresses change nothing. Enable bits above bit 3 read as zero.
- R11: The ID and version addresses return the ID_WORD and VERSION_WORD parameter values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| evt_i | input | 4 | Event indications: read, write, activate, idle |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Overflow interrupt, OR of all status bits |

## Verification
The bench narrows the counters to 10 bits so that overflow happens within a short run. It then pushes the time counter and an event counter over the top in the same cycle, and also pushes an event counter over the top on its own after the time counter has been cleared while running. A design that did not freeze after a wrap would keep counting after the interrupt. A design that let start through while a status bit was set would clear the freeze without software first acknowledging it. The bench also writes start and stop together, clears a counter in a cycle where it also increments, and writes to read-only addresses. A wrong priority between these would show up as a running monitor, a counter off by one, or a changed value.

// File: rtl/perfmon_pkg.sv
`timescale 1ns/1ps
package perfmon_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NUM_EVT  = 4;
  localparam int NUM_CNT  = NUM_EVT + 1;
  localparam int TIME_IDX = NUM_EVT;
  localparam int TIME_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] ADR_CFG    = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_CLR    = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_TIME   = 12'h020;
  localparam logic [ADDR_W-1:0] ADR_EVT0   = 12'h030;
  localparam logic [ADDR_W-1:0] ADR_VER    = 12'h3F4;
  localparam logic [ADDR_W-1:0] ADR_ID     = 12'h3F8;
  localparam int                EVT_STRIDE = 8;

  function automatic logic [ADDR_W-1:0] evt_addr(input int n);
    return ADR_EVT0 + ADDR_W'(EVT_STRIDE * n);
  endfunction
endpackage

// File: rtl/perfmon_counter.sv
`timescale 1ns/1ps
module perfmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  // wrap event; a same-cycle clear suppresses it
  assign ovf_o = inc_i & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end else if (ovf_o) begin
      flag_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/perfmon_ctrl.sv
`timescale 1ns/1ps
module perfmon_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic ovf_any_i,
  input  logic flag_any_i,
  output logic run_o
);
  logic run_q;

  // overflow beats stop beats start; start needs a clean status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else if (ovf_any_i || stop_i) begin
      run_q <= 1'b0;
    end else if (start_i && !flag_any_i) begin
      run_q <= 1'b1;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/perfmon_regs.sv
`timescale 1ns/1ps
module perfmon_regs
  import perfmon_pkg::*;
#(
  parameter int          CNT_W        = 32,
  parameter logic [31:0] ID_WORD      = 32'h0,
  parameter logic [31:0] VERSION_WORD = 32'h0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_en_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           run_i,
  input  logic [NUM_CNT-1:0]             flag_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  output logic                           start_o,
  output logic                           stop_o,
  output logic [NUM_CNT-1:0]             clr_o,
  output logic [NUM_EVT-1:0]             cfg_o,
  output logic [DATA_W-1:0]              rd_data_o
);
  logic               wr_ctrl, wr_cfg, wr_clr;
  logic [NUM_EVT-1:0] cfg_q;
  logic               unused_wdata;

  assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
  assign wr_cfg  = wr_en_i && (addr_i == ADR_CFG);
  assign wr_clr  = wr_en_i && (addr_i == ADR_CLR);

  assign start_o = wr_ctrl & wr_data_i[0];
  assign stop_o  = wr_ctrl & wr_data_i[1];
  assign clr_o   = wr_clr ? {wr_data_i[TIME_BIT], wr_data_i[NUM_EVT-1:0]} : '0;

  assign unused_wdata = ^wr_data_i[TIME_BIT-1:NUM_EVT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= wr_data_i[NUM_EVT-1:0];
    end
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      ADR_CTRL: rd_data_o = DATA_W'(run_i);
      ADR_CFG:  rd_data_o = DATA_W'(cfg_q);
      ADR_STAT: begin
        rd_data_o[TIME_BIT]    = flag_i[TIME_IDX];
        rd_data_o[NUM_EVT-1:0] = flag_i[NUM_EVT-1:0];
      end
      ADR_TIME: rd_data_o = DATA_W'(cnt_i[TIME_IDX]);
      ADR_VER:  rd_data_o = VERSION_WORD;
      ADR_ID:   rd_data_o = ID_WORD;
      default:  rd_data_o = '0;
    endcase
    for (int n = 0; n < NUM_EVT; n++) begin
      if (addr_i == evt_addr(n)) rd_data_o = DATA_W'(cnt_i[n]);
    end
  end
endmodule

// File: rtl/mem_perf_monitor.sv
`timescale 1ns/1ps
module mem_perf_monitor
  import perfmon_pkg::*;
#(
  parameter int          CNT_W        = 32,
  parameter logic [31:0] ID_WORD      = 32'h4D50_4D31,
  parameter logic [31:0] VERSION_WORD = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        evt_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  logic                          run_q;
  logic                          start, stop;
  logic [NUM_EVT-1:0]            cfg;
  logic [NUM_CNT-1:0]            clr_vec, inc_vec, ovf_vec, flag_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_arr;

  perfmon_regs #(
    .CNT_W       (CNT_W),
    .ID_WORD     (ID_WORD),
    .VERSION_WORD(VERSION_WORD)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .run_i    (run_q),
    .flag_i   (flag_vec),
    .cnt_i    (cnt_arr),
    .start_o  (start),
    .stop_o   (stop),
    .clr_o    (clr_vec),
    .cfg_o    (cfg),
    .rd_data_o(rd_data_o)
  );

  perfmon_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .ovf_any_i (|ovf_vec),
    .flag_any_i(|flag_vec),
    .run_o     (run_q)
  );

  always_comb begin
    inc_vec[TIME_IDX] = run_q;
    for (int n = 0; n < NUM_EVT; n++) begin
      inc_vec[n] = run_q & cfg[n] & evt_i[n];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perfmon_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_vec[g]),
      .inc_i (inc_vec[g]),
      .cnt_o (cnt_arr[g]),
      .ovf_o (ovf_vec[g]),
      .flag_o(flag_vec[g])
    );
  end

  assign irq_o = |flag_vec;
endmodule

// File: rtl/perfmon_checker.sv
`timescale 1ns/1ps
module perfmon_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             irq_i,
  input logic [4:0]       flag_i,
  input logic [4:0]       clr_i,
  input logic [4:0]       ovf_i,
  input logic [CNT_W-1:0] tcnt_i
);
  AST_NO_RUN_WHEN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !run_i); // R9
  AST_FREEZE_AFTER_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> !run_i); // R7
  AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i[4]) |=> tcnt_i == CNT_W'($past(tcnt_i) + 1'b1)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[4] |=> tcnt_i == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flag_i & $past(flag_i)) == $past(flag_i))); // R8
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i[4]) |=> $stable(tcnt_i)); // R3
endmodule

bind mem_perf_monitor perfmon_checker #(.CNT_W(CNT_W)) i_perfmon_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .run_i (run_q),
  .irq_i (irq_o),
  .flag_i(flag_vec),
  .clr_i (clr_vec),
  .ovf_i (ovf_vec),
  .tcnt_i(cnt_arr[4])
);

// File: tb/test_mem_perf_monitor.sv
`timescale 1ns/1ps
module test_mem_perf_monitor;
  localparam int          CNT_W = 10;
  localparam logic [31:0] ID_W  = 32'hA5C3_0001;
  localparam logic [31:0] VER_W = 32'h0001_0004;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  evt = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] m_cnt [5];
  logic [4:0]       m_flag;
  logic [3:0]       m_cfg;
  logic             m_run;

  always #2 clk = ~clk;

  mem_perf_monitor #(.CNT_W(CNT_W), .ID_WORD(ID_W), .VERSION_WORD(VER_W)) i_mem_perf_monitor (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .evt_i(evt), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_cnt[i] = '0;
    m_flag = '0; m_cfg = '0; m_run = 1'b0;
  endtask

  task automatic model_step(input logic we, input logic [11:0] a, input logic [31:0] d,
                            input logic [3:0] e);
    logic [4:0] clr, inc, ovf, flag_before;
    logic start, stop;
    flag_before = m_flag;
    clr   = (we && a == 12'h00C) ? {d[31], d[3:0]} : 5'b0;
    start = we && a == 12'h000 && d[0];
    stop  = we && a == 12'h000 && d[1];
    for (int i = 0; i < 4; i++) inc[i] = m_run && m_cfg[i] && e[i];
    inc[4] = m_run;
    ovf = '0;
    for (int i = 0; i < 5; i++) begin
      if (clr[i]) begin
        m_cnt[i] = '0; m_flag[i] = 1'b0;
      end else if (inc[i]) begin
        if (m_cnt[i] == MAXV) ovf[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1'b1;
      end
    end
    m_flag = m_flag | ovf;
    if (|ovf) m_run = 1'b0;
    else if (stop) m_run = 1'b0;
    else if (start && flag_before == 5'b0) m_run = 1'b1;
    if (we && a == 12'h004) m_cfg = d[3:0];
  endtask

  function automatic logic [31:0] exp_reg(input logic [11:0] a);
    case (a)
      12'h000: return {31'b0, m_run};
      12'h004: return {28'b0, m_cfg};
      12'h008: return {m_flag[4], 27'b0, m_flag[3:0]};
      12'h020: return 32'(m_cnt[4]);
      12'h030: return 32'(m_cnt[0]);
      12'h038: return 32'(m_cnt[1]);
      12'h040: return 32'(m_cnt[2]);
      12'h048: return 32'(m_cnt[3]);
      12'h3F4: return VER_W;
      12'h3F8: return ID_W;
      default: return 32'h0;
    endcase
  endfunction

  task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] e);
    wr_en = we; addr = a; wdata = d; evt = e;
    @(posedge clk);
    model_step(we, a, d, e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_lit(input logic [11:0] a, input logic [31:0] exp, input string tag);
    wr_en = 1'b0; addr = a;
    #0.1;
    check(tag, $sformatf("reg 0x%h", a), rdata, exp);
  endtask

  task automatic check_all(input string tag);
    logic [11:0] lst [12];
    lst = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h020, 12'h030, 12'h038,
            12'h040, 12'h048, 12'h3F4, 12'h3F8, 12'h010};
    for (int i = 0; i < 12; i++) check_lit(lst[i], exp_reg(lst[i]), tag);
    check(tag, "irq_o", {31'b0, irq}, {31'b0, |m_flag});
  endtask

  task automatic run_until_irq(input logic [3:0] e);
    for (int k = 0; k < 3000; k++) begin
      if (irq) break;
      tick(1'b0, 12'h0, 32'h0, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 fixed words, R2 unmapped reads
    check_all("R1");
    check_lit(12'h000, 32'h0, "R1");
    check("R1", "irq_o", {31'b0, irq}, 32'h0);
    check_lit(12'h3F8, ID_W, "R11");
    check_lit(12'h3F4, VER_W, "R11");
    check_lit(12'h010, 32'h0, "R2");
    check_lit(12'h3FC, 32'h0, "R2");

    // R10 enables above bit 3 read zero
    tick(1'b1, 12'h004, 32'hFFFF_FFFF, 4'h0);
    check_lit(12'h004, 32'hF, "R10");
    tick(1'b1, 12'h004, 32'h5, 4'h0);

    // R3 start, R4/R5 counting
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    check_lit(12'h000, 32'h1, "R3");
    repeat (10) tick(1'b0, 12'h0, 32'h0, 4'hF);
    tick(1'b1, 12'h000, 32'h2, 4'hF);
    check_lit(12'h000, 32'h0, "R3");
    check_lit(12'h020, 32'd11, "R4");
    check_lit(12'h030, 32'd11, "R5");
    check_lit(12'h038, 32'd0, "R5");
    check_lit(12'h040, 32'd11, "R5");
    check_lit(12'h048, 32'd0, "R5");
    repeat (5) tick(1'b0, 12'h0, 32'h0, 4'hF);
    check_lit(12'h020, 32'd11, "R3");
    check_lit(12'h030, 32'd11, "R3");
    tick(1'b1, 12'h000, 32'h3, 4'h0);
    check_lit(12'h000, 32'h0, "R3");

    // R10 read-only writes ignored
    tick(1'b1, 12'h008, 32'hFFFF_FFFF, 4'h0);
    tick(1'b1, 12'h020, 32'h1234_5678, 4'h0);
    tick(1'b1, 12'h030, 32'h0000_0077, 4'h0);
    tick(1'b1, 12'h3F8, 32'h0, 4'h0);
    tick(1'b1, 12'h3F4, 32'h0, 4'h0);
    check_all("R10");
    check_lit(12'h020, 32'd11, "R10");
    check_lit(12'h008, 32'h0, "R10");
    check_lit(12'h3F8, ID_W, "R10");

    // R6 single and all clear
    tick(1'b1, 12'h00C, 32'h4, 4'h0);
    check_lit(12'h040, 32'h0, "R6");
    check_lit(12'h030, 32'd11, "R6");
    tick(1'b1, 12'h00C, 32'h8000_000F, 4'h0);
    check_all("R6");
    check_lit(12'h020, 32'h0, "R6");

    // R7 time and event 0 wrap together
    tick(1'b1, 12'h004, 32'h1, 4'h0);
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    run_until_irq(4'h1);
    check_lit(12'h008, 32'h8000_0001, "R7");
    check_lit(12'h020, 32'h0, "R7");
    check_lit(12'h030, 32'h0, "R7");
    check_lit(12'h000, 32'h0, "R7");
    check("R8", "irq_o", {31'b0, irq}, 32'h1);
    repeat (20) tick(1'b0, 12'h0, 32'h0, 4'h1);
    check_lit(12'h020, 32'h0, "R7");
    check_lit(12'h030, 32'h0, "R7");

    // R9 start blocked until every flag cleared; R8 stickiness
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    check_lit(12'h000, 32'h0, "R9");
    tick(1'b1, 12'h00C, 32'h1, 4'h0);
    check_lit(12'h008, 32'h8000_0000, "R8");
    check("R8", "irq_o", {31'b0, irq}, 32'h1);
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    check_lit(12'h000, 32'h0, "R9");
    tick(1'b1, 12'h00C, 32'h8000_0000, 4'h0);
    check_lit(12'h008, 32'h0, "R8");
    check("R8", "irq_o", {31'b0, irq}, 32'h0);
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    check_lit(12'h000, 32'h1, "R9");
    tick(1'b1, 12'h000, 32'h2, 4'h0);
    tick(1'b1, 12'h00C, 32'h8000_000F, 4'h0);

    // R7 event counter wraps alone after time cleared mid-run (R6 clear beats increment)
    tick(1'b1, 12'h000, 32'h1, 4'h0);
    repeat (5) tick(1'b0, 12'h0, 32'h0, 4'h1);
    tick(1'b1, 12'h00C, 32'h8000_0000, 4'h1);
    check_lit(12'h020, 32'h0, "R6");
    check_lit(12'h030, 32'd6, "R6");
    run_until_irq(4'h1);
    check_lit(12'h008, 32'h0000_0001, "R7");
    check_all("R7");
    tick(1'b1, 12'h00C, 32'h8000_000F, 4'h0);

    // constrained random mix
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [3:0]  e;
      logic [31:0] r;
      e = 4'($urandom);
      r = $urandom % 16;
      case (r)
        0: tick(1'b1, 12'h000, $urandom % 4, e);
        1: tick(1'b1, 12'h004, $urandom, e);
        2: tick(1'b1, 12'h00C, ($urandom % 4 == 0) ? 32'h8000_000F : ($urandom & 32'h8000_000F), e);
        3: tick(1'b1, 12'h008 + 12'(($urandom % 4) * 8), $urandom, e);
        4: tick(1'b1, 12'h000, 32'h1, e);
        default: tick(1'b0, 12'h0, 32'h0, e);
      endcase
      check("R8", "irq_o", {31'b0, irq}, {31'b0, |m_flag});
      if (cyc % 32 == 31) check_all("R5");
    end
    check_all("R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule